// File: doc/BRIEF.md
# Method Write Dispatcher with Macro Trigger

This block sits behind a command front end and takes one method write per handshake. Each write carries a method index, a 32-bit value and the number of parameter words still to come in its packet. Indices below the macro boundary address a register file. A few chosen indices also fire a one-cycle side-effect strobe. Indices at or above the boundary are never stored. They start or extend a macro call instead. The argument words go into a parameter FIFO, and when the packet ends a start request is handed to an external macro executor. The executor reads the code words and pops the arguments itself.

Macro code is loaded through the register side. A write to the code-data register appends its value to the code of the slot named by the slot-select register. Slot n belongs to trigger index 0xE00 + 2n. The odd index just above each trigger carries the call's further arguments.

The write input is valid/ready. A write is taken on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` drops while a start request is pending and rises again in the cycle after the executor raises `mstart_ready`. The start request and the parameter output are valid/ready as well. A parameter word leaves the FIFO on an edge where `prm_valid` and `prm_ready` are both high.

Top module: `mthd_dispatch`

## Requirements
- R1: After reset `wr_ready`=1, `mstart_valid`=0, `prm_valid`=0, every error output is 0 and every register reads 0.
- R2: An accepted write in the idle state with index below 128 (REG_COUNT) is stored and can be read on `rd_data` from the next cycle.
- R3: An accepted register write to index 0x030, 0x031, 0x050 or 0x060 drives `fx_strobe` high for exactly the next cycle, with `fx_method` equal to that index. Other indices leave `fx_strobe` low.
- R4: An index from 128 up to 0xDFF raises `err_range` for one cycle and stores nothing.
- R5: An index of 0xE00 or above never writes the register file. An even index while idle starts a call, and its value becomes the first parameter.
- R6: An odd index of 0xE00 or above while idle raises `err_odd_start` for one cycle. The write is dropped and the block stays idle.
- R7: While a call collects arguments, only the index of the starting trigger plus one is appended. Any other index raises `err_seq` for one cycle and is dropped, and collection goes on.
- R8: A macro write with `wr_remaining`=0 ends the call. If the slot has code, `mstart_valid` rises in the next cycle with the slot number (index-0xE00)/2, the parameter count and the code length, and `wr_ready` stays low until `mstart_ready` is seen.
- R9: A value written to register 0x045 is appended to the code of the slot given by bits [2:0] of register 0x046. It can be read at `code_rd_slot`/`code_rd_addr` with address 0 holding the first word.
- R10: A call that ends on a slot without code raises `err_no_code` for one cycle. Its parameters are discarded and the block returns to idle with no start request.
- R11: The parameter FIFO holds 32 words in arrival order. A push into a full FIFO is dropped and sets the sticky `err_overflow`. A push and a pop on the same edge at full count is not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Method write offered |
| wr_ready | output | 1 | Method write can be taken |
| wr_method | input | 12 | Method index |
| wr_value | input | 32 | Method value |
| wr_remaining | input | 8 | Parameter words still pending in the packet |
| rd_idx | input | 7 | Register read index |
| rd_data | output | 32 | Register read data |
| fx_strobe | output | 1 | One-cycle side-effect pulse |
| fx_method | output | 12 | Index that caused the pulse |
| mstart_valid | output | 1 | Macro start request pending |
| mstart_ready | input | 1 | Executor takes the start request |
| mstart_slot | output | 3 | Macro slot to run |
| mstart_nparams | output | 6 | Parameter words stored for this call |
| mstart_len | output | 5 | Code words in the slot |
| prm_valid | output | 1 | Parameter word available |
| prm_ready | input | 1 | Executor pops a parameter word |
| prm_data | output | 32 | Oldest parameter word |
| code_rd_slot | input | 3 | Code read slot |
| code_rd_addr | input | 4 | Code read word address |
| code_rd_data | output | 32 | Code word |
| err_range | output | 1 | Register index beyond the file |
| err_odd_start | output | 1 | Call started on an odd index |
| err_seq | output | 1 | Wrong index during collection |
| err_no_code | output | 1 | Call on an empty slot |
| err_overflow | output | 1 | Sticky parameter FIFO overflow |

## Verification
Two functions can meet on the same clock edge. The executor can pop a parameter left over from an earlier call while a new call pushes its first word, and the FIFO can be full at that moment. The bench fills the FIFO with a 32-word call and lets the executor take the start. It then offers a one-word call in the same cycle as a single pop. The pass condition is that `err_overflow` stays clear, the new call reports one parameter, and all 32 old words followed by the new word drain in order.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
  typedef enum logic [1:0] {
    MS_IDLE    = 2'd0,
    MS_COLLECT = 2'd1,
    MS_LAUNCH  = 2'd2
  } mstate_t;
endpackage

// File: rtl/mdisp_param_fifo.sv
module mdisp_param_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  output logic                       push_ok,
  input  logic                       pop,
  output logic                       out_valid,
  output logic [DW-1:0]              out_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign pop_ok    = pop && out_valid;
  // a pop on the same edge frees the slot the push needs
  assign push_ok   = push && !flush && ((level < CW'(DEPTH)) || pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      if (push_ok && !pop_ok)      level <= level + CW'(1);
      else if (!push_ok && pop_ok) level <= level - CW'(1);
      if (push && !push_ok) overflow <= 1'b1;
    end
  end

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/mdisp_code_store.sv
module mdisp_code_store #(
  parameter int DW    = 32,
  parameter int SLOTS = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(SLOTS)-1:0]   wr_slot,
  input  logic [DW-1:0]              wr_data,
  input  logic [$clog2(SLOTS)-1:0]   q_slot,
  output logic [$clog2(DEPTH+1)-1:0] q_len,
  input  logic [$clog2(SLOTS)-1:0]   rd_slot,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [DW-1:0]              rd_data
);
  localparam int SW = $clog2(SLOTS);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [SLOTS*DEPTH];
  logic [LW-1:0] lens [SLOTS];
  logic          room;

  assign room    = lens[wr_slot] < LW'(DEPTH);
  assign q_len   = lens[q_slot];
  assign rd_data = mem[{rd_slot, rd_addr}];

  always_ff @(posedge clk) begin
    if (wr_en && room) mem[{wr_slot, lens[wr_slot][AW-1:0]}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) lens[s] <= '0;
    end else if (wr_en && room) begin
      lens[wr_slot] <= lens[wr_slot] + LW'(1);
    end
  end

  a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_len <= LW'(DEPTH));
  a_r9_append_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && room && q_slot == wr_slot) |=> (q_len != '0) || (q_slot != $past(wr_slot)));
endmodule

// File: rtl/mdisp_regfile.sv
module mdisp_regfile #(
  parameter int          DW      = 32,
  parameter int          MW      = 12,
  parameter int          NREG    = 128,
  parameter int          SLOTS   = 8,
  parameter int          SEL_IDX = 'h46,
  parameter int          NFX     = 4,
  parameter logic [NFX*MW-1:0] FX_IDX = {12'h060, 12'h050, 12'h031, 12'h030}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [MW-1:0]             wr_method,
  input  logic [DW-1:0]             wr_data,
  input  logic [$clog2(NREG)-1:0]   rd_idx,
  output logic [DW-1:0]             rd_data,
  output logic [$clog2(SLOTS)-1:0]  sel_slot,
  output logic                      fx_strobe,
  output logic [MW-1:0]             fx_method
);
  localparam int IW = $clog2(NREG);
  localparam int SW = $clog2(SLOTS);

  logic [DW-1:0]  regs [NREG];
  logic [NFX-1:0] hit;

  for (genvar g = 0; g < NFX; g++) begin : g_fx
    assign hit[g] = (wr_method == FX_IDX[g*MW +: MW]);
  end

  assign rd_data  = regs[rd_idx];
  assign sel_slot = regs[SEL_IDX][SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      fx_strobe <= 1'b0;
      fx_method <= '0;
    end else begin
      if (wr_en) regs[wr_method[IW-1:0]] <= wr_data;
      fx_strobe <= wr_en && (|hit);
      if (wr_en && (|hit)) fx_method <= wr_method;
    end
  end

  a_r3_fx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fx_strobe |-> $past(wr_en));
endmodule

// File: rtl/mthd_dispatch.sv
module mthd_dispatch #(
  parameter int             DW          = 32,
  parameter int             MW          = 12,
  parameter int             RW          = 8,
  parameter int             REG_COUNT   = 128,
  parameter logic [11:0]    MACRO_BASE  = 12'hE00,
  parameter int             SLOTS       = 8,
  parameter int             CODE_DEPTH  = 16,
  parameter int             PARAM_DEPTH = 32,
  parameter int             MDATA_IDX   = 'h45,
  parameter int             SEL_IDX     = 'h46
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [MW-1:0]                    wr_method,
  input  logic [DW-1:0]                    wr_value,
  input  logic [RW-1:0]                    wr_remaining,
  input  logic [$clog2(REG_COUNT)-1:0]     rd_idx,
  output logic [DW-1:0]                    rd_data,
  output logic                             fx_strobe,
  output logic [MW-1:0]                    fx_method,
  output logic                             mstart_valid,
  input  logic                             mstart_ready,
  output logic [$clog2(SLOTS)-1:0]         mstart_slot,
  output logic [$clog2(PARAM_DEPTH+1)-1:0] mstart_nparams,
  output logic [$clog2(CODE_DEPTH+1)-1:0]  mstart_len,
  output logic                             prm_valid,
  input  logic                             prm_ready,
  output logic [DW-1:0]                    prm_data,
  input  logic [$clog2(SLOTS)-1:0]         code_rd_slot,
  input  logic [$clog2(CODE_DEPTH)-1:0]    code_rd_addr,
  output logic [DW-1:0]                    code_rd_data,
  output logic                             err_range,
  output logic                             err_odd_start,
  output logic                             err_seq,
  output logic                             err_no_code,
  output logic                             err_overflow
);
  import mdisp_pkg::*;

  localparam int SW  = $clog2(SLOTS);
  localparam int LW  = $clog2(CODE_DEPTH + 1);
  localparam int PCW = $clog2(PARAM_DEPTH + 1);

  mstate_t        st;
  logic [MW-1:0]  trig_q;
  logic [SW-1:0]  trig_slot_q;
  logic           trig_ok_q;
  logic [PCW-1:0] pcnt_q;

  logic           acc, is_macro, in_rng, legal, push, push_ok, final_wr, empty;
  logic           reg_we, up_we, cand_ok, cur_ok;
  logic [MW-1:0]  cand;
  logic [SW-1:0]  cur_slot, sel_slot;
  logic [LW-1:0]  q_len;
  logic [PCW-1:0] fifo_level;

  assign wr_ready = (st != MS_LAUNCH);
  assign acc      = wr_valid && wr_ready;
  assign is_macro = (wr_method >= MACRO_BASE);
  assign in_rng   = !is_macro && (wr_method < MW'(REG_COUNT));
  assign cand     = (wr_method - MACRO_BASE) >> 1;
  assign cand_ok  = cand < MW'(SLOTS);
  assign legal    = (wr_method == trig_q + MW'(1));

  assign reg_we   = acc && (st == MS_IDLE) && in_rng;
  assign up_we    = reg_we && (wr_method == MW'(MDATA_IDX));
  assign push     = acc && is_macro &&
                    (((st == MS_IDLE) && !wr_method[0]) || ((st == MS_COLLECT) && legal));
  assign final_wr = push && (wr_remaining == '0);
  assign cur_slot = (st == MS_IDLE) ? cand[SW-1:0] : trig_slot_q;
  assign cur_ok   = (st == MS_IDLE) ? cand_ok : trig_ok_q;
  assign empty    = !cur_ok || (q_len == '0);

  mdisp_regfile #(
    .DW(DW), .MW(MW), .NREG(REG_COUNT), .SLOTS(SLOTS), .SEL_IDX(SEL_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_method(wr_method),
    .wr_data(wr_value), .rd_idx(rd_idx), .rd_data(rd_data),
    .sel_slot(sel_slot), .fx_strobe(fx_strobe), .fx_method(fx_method)
  );

  mdisp_code_store #(
    .DW(DW), .SLOTS(SLOTS), .DEPTH(CODE_DEPTH)
  ) u_code (
    .clk(clk), .rst_n(rst_n), .wr_en(up_we), .wr_slot(sel_slot),
    .wr_data(wr_value), .q_slot(cur_slot), .q_len(q_len),
    .rd_slot(code_rd_slot), .rd_addr(code_rd_addr), .rd_data(code_rd_data)
  );

  mdisp_param_fifo #(
    .DW(DW), .DEPTH(PARAM_DEPTH)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(final_wr && empty), .push(push),
    .push_data(wr_value), .push_ok(push_ok), .pop(prm_ready),
    .out_valid(prm_valid), .out_data(prm_data), .level(fifo_level),
    .overflow(err_overflow)
  );

  assign mstart_valid   = (st == MS_LAUNCH);
  assign mstart_slot    = trig_slot_q;
  assign mstart_nparams = pcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= MS_IDLE;
      trig_q        <= '0;
      trig_slot_q   <= '0;
      trig_ok_q     <= 1'b0;
      pcnt_q        <= '0;
      mstart_len    <= '0;
      err_range     <= 1'b0;
      err_odd_start <= 1'b0;
      err_seq       <= 1'b0;
      err_no_code   <= 1'b0;
    end else begin
      err_range     <= acc && (st == MS_IDLE) && !is_macro && !in_rng;
      err_odd_start <= acc && (st == MS_IDLE) && is_macro && wr_method[0];
      err_seq       <= acc && (st == MS_COLLECT) && !legal;
      err_no_code   <= final_wr && empty;
      if (push) begin
        pcnt_q <= ((st == MS_IDLE) ? '0 : pcnt_q) + PCW'(push_ok);
      end
      if (push && (st == MS_IDLE)) begin
        trig_q      <= wr_method;
        trig_slot_q <= cand[SW-1:0];
        trig_ok_q   <= cand_ok;
      end
      case (st)
        MS_IDLE, MS_COLLECT: begin
          if (final_wr) begin
            st <= empty ? MS_IDLE : MS_LAUNCH;
            mstart_len <= q_len;
          end else if (push) begin
            st <= MS_COLLECT;
          end
        end
        MS_LAUNCH: if (mstart_ready) st <= MS_IDLE;
        default: st <= MS_IDLE;
      endcase
    end
  end

  a_r8_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mstart_valid && !mstart_ready) |=> (mstart_valid && $stable(mstart_slot)));
  a_r8_nparams_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mstart_valid |-> (mstart_nparams <= PCW'(PARAM_DEPTH)) && (fifo_level >= mstart_nparams || prm_valid || fifo_level == '0));
  a_r6_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_range, err_odd_start, err_seq, err_no_code}));
  a_r10_no_start_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_code |-> !mstart_valid && !prm_valid);
endmodule

// File: tb/mthd_dispatch_test.sv
module mthd_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [11:0] wr_method = '0;
  logic [31:0] wr_value = '0;
  logic [7:0]  wr_remaining = '0;
  logic [6:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        fx_strobe;
  logic [11:0] fx_method;
  logic        mstart_valid;
  logic        mstart_ready = 1'b0;
  logic [2:0]  mstart_slot;
  logic [5:0]  mstart_nparams;
  logic [4:0]  mstart_len;
  logic        prm_valid;
  logic        prm_ready = 1'b0;
  logic [31:0] prm_data;
  logic [2:0]  code_rd_slot = '0;
  logic [3:0]  code_rd_addr = '0;
  logic [31:0] code_rd_data;
  logic        err_range, err_odd_start, err_seq, err_no_code, err_overflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mthd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_method(wr_method), .wr_value(wr_value), .wr_remaining(wr_remaining),
    .rd_idx(rd_idx), .rd_data(rd_data), .fx_strobe(fx_strobe), .fx_method(fx_method),
    .mstart_valid(mstart_valid), .mstart_ready(mstart_ready), .mstart_slot(mstart_slot),
    .mstart_nparams(mstart_nparams), .mstart_len(mstart_len),
    .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data),
    .code_rd_slot(code_rd_slot), .code_rd_addr(code_rd_addr), .code_rd_data(code_rd_data),
    .err_range(err_range), .err_odd_start(err_odd_start), .err_seq(err_seq),
    .err_no_code(err_no_code), .err_overflow(err_overflow)
  );

  // method, value, side-effect expected
  localparam logic [44:0] VEC [8] = '{
    {12'h001, 32'h1111_0001, 1'b0},
    {12'h030, 32'h2222_0030, 1'b1},
    {12'h031, 32'h3333_0031, 1'b1},
    {12'h010, 32'h4444_0010, 1'b0},
    {12'h050, 32'h5555_0050, 1'b1},
    {12'h07F, 32'h6666_007F, 1'b0},
    {12'h060, 32'h7777_0060, 1'b1},
    {12'h044, 32'h8888_0044, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // offers one write; returns at the negedge after it was taken
  task automatic send(input logic [11:0] m, input logic [31:0] v, input logic [7:0] rem);
    @(negedge clk);
    wr_valid = 1'b1; wr_method = m; wr_value = v; wr_remaining = rem;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take_start();
    mstart_ready = 1'b1;
    @(negedge clk);
    mstart_ready = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [31:0] exp);
    check(req, {31'd0, prm_valid}, 32'd1);
    check(req, prm_data, exp);
    prm_ready = 1'b1;
    @(negedge clk);
    prm_ready = 1'b0;
  endtask

  task automatic read_reg(input logic [6:0] idx, output logic [31:0] d);
    rd_idx = idx;
    #1 d = rd_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    check("R1 mstart_valid", {31'd0, mstart_valid}, 32'd0);
    check("R1 prm_valid", {31'd0, prm_valid}, 32'd0);
    check("R1 errors", {27'd0, err_range, err_odd_start, err_seq, err_no_code, err_overflow}, 32'd0);
    read_reg(7'h05, d); check("R1 reg clear", d, 32'd0);

    // R2 / R3 register writes from the vector table
    for (int i = 0; i < 8; i++) begin
      send(VEC[i][44:33], VEC[i][32:1], 8'd0);
      check("R3 fx_strobe", {31'd0, fx_strobe}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) check("R3 fx_method", {20'd0, fx_method}, {20'd0, VEC[i][44:33]});
      @(negedge clk);
      check("R3 strobe one cycle", {31'd0, fx_strobe}, 32'd0);
      read_reg(VEC[i][39:33], d); check("R2 stored", d, VEC[i][32:1]);
    end

    // R4 out-of-range index aliases onto reg 0, which must stay clear
    send(12'h100, 32'hDEAD_BEEF, 8'd0);
    check("R4 err_range", {31'd0, err_range}, 32'd1);
    read_reg(7'h00, d); check("R4 not stored", d, 32'd0);

    // R9 upload three words to slot 1
    send(12'h046, 32'd1, 8'd0);
    send(12'h045, 32'hC0DE_00AA, 8'd0);
    send(12'h045, 32'hC0DE_00BB, 8'd0);
    send(12'h045, 32'hC0DE_00CC, 8'd0);
    code_rd_slot = 3'd1; code_rd_addr = 4'd0; #1 check("R9 code word0", code_rd_data, 32'hC0DE_00AA);
    code_rd_addr = 4'd2; #1 check("R9 code word2", code_rd_data, 32'hC0DE_00CC);

    // R5 / R8 three-word call on slot 1
    send(12'hE02, 32'd11, 8'd2);
    check("R5 still collecting", {31'd0, mstart_valid}, 32'd0);
    send(12'hE03, 32'd22, 8'd1);
    send(12'hE03, 32'd33, 8'd0);
    check("R8 start valid", {31'd0, mstart_valid}, 32'd1);
    check("R8 wr_ready low", {31'd0, wr_ready}, 32'd0);
    check("R8 slot", {29'd0, mstart_slot}, 32'd1);
    check("R8 nparams", {26'd0, mstart_nparams}, 32'd3);
    check("R8 code len", {27'd0, mstart_len}, 32'd3);
    @(negedge clk);
    check("R8 start held", {31'd0, mstart_valid}, 32'd1);
    take_start();
    check("R8 released", {30'd0, mstart_valid, wr_ready}, 32'd1);
    pop_check("R11 order p0", 32'd11);
    pop_check("R11 order p1", 32'd22);
    pop_check("R11 order p2", 32'd33);
    read_reg(7'h02, d); check("R5 macro not stored", d, 32'd0);

    // R6 odd start
    send(12'hE05, 32'd99, 8'd0);
    check("R6 err_odd_start", {31'd0, err_odd_start}, 32'd1);
    check("R6 no start", {30'd0, mstart_valid, prm_valid}, 32'd0);

    // R7 wrong index during collection
    send(12'hE02, 32'd5, 8'd1);
    send(12'hE07, 32'd6, 8'd0);
    check("R7 err_seq", {31'd0, err_seq}, 32'd1);
    check("R7 no start yet", {31'd0, mstart_valid}, 32'd0);
    send(12'h010, 32'd6, 8'd0);
    check("R7 reg write rejected", {31'd0, err_seq}, 32'd1);
    send(12'hE03, 32'd7, 8'd0);
    check("R7 nparams", {26'd0, mstart_nparams}, 32'd2);
    take_start();
    pop_check("R7 p0", 32'd5);
    pop_check("R7 p1", 32'd7);
    read_reg(7'h10, d); check("R7 reg unchanged", d, 32'h4444_0010);

    // R10 call on empty slot 2
    send(12'hE04, 32'd1, 8'd1);
    send(12'hE05, 32'd2, 8'd0);
    check("R10 err_no_code", {31'd0, err_no_code}, 32'd1);
    check("R10 no start, flushed", {30'd0, mstart_valid, prm_valid}, 32'd0);

    // R11 full FIFO with same-edge push and pop
    for (int i = 0; i < 32; i++)
      send(i == 0 ? 12'hE02 : 12'hE03, 32'h100 + i, 8'(31 - i));
    check("R11 full call nparams", {26'd0, mstart_nparams}, 32'd32);
    take_start();
    @(negedge clk);
    wr_valid = 1'b1; wr_method = 12'hE02; wr_value = 32'h77; wr_remaining = 8'd0;
    prm_ready = 1'b1;
    check("R11 head before collide", prm_data, 32'h100);
    @(negedge clk);
    wr_valid = 1'b0; prm_ready = 1'b0;
    check("R11 no overflow on collide", {31'd0, err_overflow}, 32'd0);
    check("R11 collide nparams", {26'd0, mstart_nparams}, 32'd1);
    take_start();
    for (int i = 1; i < 32; i++) begin
      check("R11 drain", prm_data, 32'h100 + i);
      prm_ready = 1'b1; @(negedge clk); prm_ready = 1'b0;
    end
    pop_check("R11 new word last", 32'h77);

    // R11 overflow with 33 words
    for (int i = 0; i < 33; i++)
      send(i == 0 ? 12'hE02 : 12'hE03, 32'h200 + i, 8'(32 - i));
    check("R11 err_overflow", {31'd0, err_overflow}, 32'd1);
    check("R11 overflow nparams", {26'd0, mstart_nparams}, 32'd32);
    take_start();
    for (int i = 0; i < 32; i++) begin
      check("R11 overflow drain", prm_data, 32'h200 + i);
      prm_ready = 1'b1; @(negedge clk); prm_ready = 1'b0;
    end
    check("R11 empty after drain", {31'd0, prm_valid}, 32'd0);
    check("R11 overflow sticky", {31'd0, err_overflow}, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule